// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the control-store address of the next microinstruction in a microprogrammed control unit. Every cycle it looks at the branch-kind code and target field of the current microinstruction. It also looks at the condition flags, the addressing-mode bits of the machine instruction, its opcode and the memory handshake. From these it moves the registered micro-address to its next value.

Shared microroutines branch to one base target. The sequencer then ORs the decoded mode bits into the low bits of that target. Bit 0 of the mode input stands for direct addressing. An operand-fetch step at an even address, such as 170, is therefore skipped by landing on 171. When a microinstruction waits on memory, the address holds until memory reports completion.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `uaddr` equals the fetch address `FETCH_ADDR` (default 0).
- R2: Branch code 0 (sequential) advances `uaddr` by one, modulo 2^`AW`, at the next clock. Codes 6 and 7 are reserved and behave like code 0.
- R3: Branch code 1 (jump) loads `br_target` into `uaddr` at the next clock.
- R4: Branch code 2 (conditional) loads `br_target` when `cond_flags[cond_sel]` is 1. Otherwise it advances `uaddr` by one.
- R5: Branch code 3 (mode merge) loads `br_target` with its low `MODE_W` bits ORed with `mode_bits`. `mode_bits[0]`=1 marks direct addressing, so target 170 becomes 171 and the indirect case stays at 170.
- R6: Branch code 4 (end of routine) loads `FETCH_ADDR`.
- R7: Branch code 5 (dispatch) loads `DISPATCH_BASE + opcode * 2^STRIDE_LOG2`, modulo 2^`AW`. The defaults are base 0x40 and stride 4.
- R8: While `wait_mem`=1 and `mem_done`=0, `uaddr` keeps its value whatever the branch code is. With `wait_mem`=1 and `mem_done`=1, the branch code acts normally.
- R9: While `wait_mem`=0, the value of `mem_done` has no effect on the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_code | input | 3 | Branch kind of the current microinstruction |
| br_target | input | AW | Target address field |
| cond_sel | input | $clog2(NCOND) | Index of the condition flag to test |
| cond_flags | input | NCOND | Condition code flags and external conditions |
| mode_bits | input | MODE_W | Decoded addressing-mode bits; bit 0 = direct |
| opcode | input | OPC_W | Opcode of the machine instruction |
| wait_mem | input | 1 | Microinstruction waits for memory completion |
| mem_done | input | 1 | Memory function completed |
| uaddr | output | AW | Current micro-address |

## Verification
The hardest situation to reach is a wait on memory that falls on a microinstruction that would otherwise branch. Only then does holding the address differ from what the branch would have done. The bench sweeps every branch code against every combination of `wait_mem` and `mem_done`, every flag pattern and select, and every mode value. Each stalled cycle is therefore tried against every branch kind, and each released cycle is compared with the branch the code asks for.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  typedef enum logic [2:0] {
    BR_SEQ      = 3'd0,
    BR_JUMP     = 3'd1,
    BR_COND     = 3'd2,
    BR_MODE     = 3'd3,
    BR_END      = 3'd4,
    BR_DISPATCH = 3'd5,
    BR_RSV6     = 3'd6,
    BR_RSV7     = 3'd7
  } br_kind_e;
endpackage

// File: rtl/useq_cond_sel.sv
`timescale 1ns/1ps
module useq_cond_sel #(
  parameter int NCOND = 4,
  localparam int SEL_W = (NCOND > 1) ? $clog2(NCOND) : 1
) (
  input  logic [NCOND-1:0] flags,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NCOND; i++) begin
      if (sel == SEL_W'(i)) hit = flags[i];
    end
  end
endmodule

// File: rtl/useq_next_mux.sv
`timescale 1ns/1ps
module useq_next_mux
  import useq_pkg::*;
#(
  parameter int          AW            = 8,
  parameter int          MODE_W        = 2,
  parameter int          OPC_W         = 4,
  parameter int          STRIDE_LOG2   = 2,
  parameter logic [AW-1:0] FETCH_ADDR    = '0,
  parameter logic [AW-1:0] DISPATCH_BASE = AW'(64)
) (
  input  logic [AW-1:0]     cur,
  input  br_kind_e          kind,
  input  logic [AW-1:0]     target,
  input  logic [MODE_W-1:0] mode_bits,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              cond_hit,
  output logic [AW-1:0]     nxt
);
  function automatic logic [AW-1:0] f_merge(input logic [AW-1:0] t,
                                            input logic [MODE_W-1:0] m);
    logic [AW-1:0] wide;
    wide = '0;
    wide[MODE_W-1:0] = m;
    return t | wide;
  endfunction

  function automatic logic [AW-1:0] f_dispatch(input logic [OPC_W-1:0] op);
    logic [AW-1:0] off;
    off = AW'(op) << STRIDE_LOG2;
    return DISPATCH_BASE + off;
  endfunction

  logic [AW-1:0] inc_addr;
  assign inc_addr = cur + AW'(1);

  always_comb begin
    unique case (kind)
      BR_JUMP:     nxt = target;
      BR_COND:     nxt = cond_hit ? target : inc_addr;
      BR_MODE:     nxt = f_merge(target, mode_bits);
      BR_END:      nxt = FETCH_ADDR;
      BR_DISPATCH: nxt = f_dispatch(opcode);
      default:     nxt = inc_addr;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
`timescale 1ns/1ps
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int            AW            = 8,
  parameter int            NCOND         = 4,
  parameter int            MODE_W        = 2,
  parameter int            OPC_W         = 4,
  parameter int            STRIDE_LOG2   = 2,
  parameter logic [AW-1:0] FETCH_ADDR    = '0,
  parameter logic [AW-1:0] DISPATCH_BASE = AW'(64),
  localparam int SEL_W = (NCOND > 1) ? $clog2(NCOND) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        br_code,
  input  logic [AW-1:0]     br_target,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [NCOND-1:0]  cond_flags,
  input  logic [MODE_W-1:0] mode_bits,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              wait_mem,
  input  logic              mem_done,
  output logic [AW-1:0]     uaddr
);
  br_kind_e      kind;
  logic          cond_hit;
  logic          stall;
  logic [AW-1:0] nxt_addr;

  assign kind  = br_kind_e'(br_code);
  assign stall = wait_mem & ~mem_done;

  useq_cond_sel #(.NCOND(NCOND)) cond_i (
    .flags(cond_flags), .sel(cond_sel), .hit(cond_hit)
  );

  useq_next_mux #(
    .AW(AW), .MODE_W(MODE_W), .OPC_W(OPC_W), .STRIDE_LOG2(STRIDE_LOG2),
    .FETCH_ADDR(FETCH_ADDR), .DISPATCH_BASE(DISPATCH_BASE)
  ) mux_i (
    .cur(uaddr), .kind(kind), .target(br_target), .mode_bits(mode_bits),
    .opcode(opcode), .cond_hit(cond_hit), .nxt(nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     uaddr <= FETCH_ADDR;
    else if (!stall) uaddr <= nxt_addr;
  end

  assert_hold_on_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mem && !mem_done) |=> $stable(uaddr));

  assert_seq_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_SEQ && !stall) |=> (uaddr == AW'($past(uaddr) + AW'(1))));

  assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_JUMP && !stall) |=> (uaddr == $past(br_target)));

  assert_cond_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_COND && !stall && !cond_hit) |=> (uaddr == AW'($past(uaddr) + AW'(1))));

  assert_mode_bits_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_MODE && !stall) |=>
      ((uaddr[MODE_W-1:0] & $past(mode_bits)) == $past(mode_bits)));

  assert_end_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_END && !stall) |=> (uaddr == FETCH_ADDR));
endmodule

// File: tb/useq_sequencer_tb_top.sv
`timescale 1ns/1ps
module useq_sequencer_tb_top;
  localparam int AW = 8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] br_code = '0;
  logic [7:0] br_target = '0;
  logic [1:0] cond_sel = '0;
  logic [3:0] cond_flags = '0;
  logic [1:0] mode_bits = '0;
  logic [3:0] opcode = '0;
  logic       wait_mem = 1'b0;
  logic       mem_done = 1'b0;
  logic [7:0] uaddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] exp_addr = '0;

  always #2 clk = ~clk;

  useq_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .br_code(br_code), .br_target(br_target),
    .cond_sel(cond_sel), .cond_flags(cond_flags), .mode_bits(mode_bits),
    .opcode(opcode), .wait_mem(wait_mem), .mem_done(mem_done), .uaddr(uaddr)
  );

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (uaddr !== exp) begin
      failures++;
      $display("FAIL %s uaddr=%0d expected=%0d", req, uaddr, exp);
    end
  endtask

  // advance one clock and sample 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] model(input logic [7:0] cur);
    if (wait_mem && !mem_done) return cur;
    case (br_code)
      3'd1: return br_target;
      3'd2: return cond_flags[cond_sel] ? br_target : cur + 8'd1;
      3'd3: return br_target | {6'd0, mode_bits};
      3'd4: return 8'd0;
      3'd5: return 8'd64 + 8'(opcode) * 8'd4;
      default: return cur + 8'd1;
    endcase
  endfunction

  function automatic string req_of();
    if (wait_mem && !mem_done) return "R8";
    if (!wait_mem && mem_done) return "R9";
    case (br_code)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic apply_and_check(input string req);
    exp_addr = model(exp_addr);
    tick();
    check(req, exp_addr);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired uaddr=%0d expected=done", uaddr);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(); tick();
    check("R1", 8'd0);
    rst_n = 1'b1;
    exp_addr = 8'd0;
    tick();
    check("R1", 8'd0 + 8'd1);
    exp_addr = 8'd1;

    // R5: indirect stays at 170, direct lands on 171
    br_code = 3'd3; br_target = 8'd170; mode_bits = 2'b00;
    apply_and_check("R5");
    check("R5", 8'd170);
    mode_bits = 2'b01;
    apply_and_check("R5");
    check("R5", 8'd171);

    // R2: wrap at top of address space
    br_code = 3'd1; br_target = 8'hFF; mode_bits = 2'b00;
    apply_and_check("R3");
    br_code = 3'd0;
    apply_and_check("R2");
    check("R2", 8'd0);

    // R8: long hold then release into a jump
    br_code = 3'd1; br_target = 8'd99; wait_mem = 1'b1; mem_done = 1'b0;
    for (int k = 0; k < 5; k++) apply_and_check("R8");
    mem_done = 1'b1;
    apply_and_check("R8");
    check("R8", 8'd99);
    wait_mem = 1'b0; mem_done = 1'b0;

    // sweep of every code against handshake, flags, select and mode
    for (int code = 0; code < 8; code++)
      for (int hs = 0; hs < 4; hs++)
        for (int sel = 0; sel < 4; sel++)
          for (int fl = 0; fl < 16; fl++)
            for (int md = 0; md < 4; md++) begin
              br_code    = 3'(code);
              wait_mem   = hs[1];
              mem_done   = hs[0];
              cond_sel   = 2'(sel);
              cond_flags = 4'(fl);
              mode_bits  = 2'(md);
              br_target  = 8'((fl * 37 + md * 11 + code * 5 + sel) & 8'hFC) | 8'(fl & 3);
              opcode     = 4'(fl + sel + md);
              apply_and_check(req_of());
            end

    // R1: reset in mid-run
    br_code = 3'd1; br_target = 8'd200; wait_mem = 1'b0; mem_done = 1'b0;
    apply_and_check("R3");
    rst_n = 1'b0;
    tick();
    check("R1", 8'd0);
    rst_n = 1'b1;
    exp_addr = 8'd0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule